// File: doc/BRIEF.md
# Memory-Backed Accumulator Bank with Running Maximum

This block holds a bank of accumulators in an inferred RAM rather than in flip-flops. Each update request names one accumulator and carries an unsigned addend. A single shared adder performs a read-modify-write on that entry: the entry is read in the acceptance cycle, the sum is formed and written back in the cycle after, and the sum wraps modulo 2^ACC_W. The RAM is built either with one port or with separate read and write ports. With one port, the read and the write of an update take turns, so the bank accepts at most one update every two clocks. With two ports, it accepts one update every clock. In two-port mode, an update that reads an entry while the previous update is still writing that same entry takes the just-computed sum from a forward path instead of the stale RAM word.

Next to the bank, a tracker keeps the largest value written since the last clear, together with the index of the entry that holds it. No scan of the RAM is needed once the updates stop. A clear command, and also reset, sweeps the RAM to zero at one address per clock. During the sweep the update port is held not ready, and the sweep also resets the maximum to zero with index 0.

The controller has two states. SWEEP writes zeros through the RAM. SERVE accepts updates. Reset enters SWEEP. SWEEP moves to SERVE after the last address has been written. SERVE moves to SWEEP in a cycle where `clr_req` is high.

Top module: `accum_bank_max`

## Requirements
- R1: An accepted update (`upd_valid` and `upd_ready` both high at a rising edge) with `upd_index` below N_ENTRIES adds `upd_addend` to that entry. The sum wraps modulo 2^ACC_W.
- R2: With DUAL_PORT=0, `upd_ready` is low in the cycle after every accepted update. It rises again one cycle later if no clear is requested.
- R3: With DUAL_PORT=1, `upd_ready` stays high in SERVE while `clr_req` is low, so one update is accepted every clock. Consecutive updates to the same index all take effect.
- R4: `max_value` equals the largest sum written since the last clear or reset, and `max_index` names the entry that was written with it. Both are updated at the second rising edge after acceptance.
- R5: A write whose sum equals the current `max_value` leaves `max_index` unchanged. Only a strictly greater sum moves it.
- R6: `clr_req` high in SERVE makes `upd_ready` low in that cycle. The request is followed by exactly N_ENTRIES cycles with `upd_ready` low, during which every entry is zeroed. After the sweep, `max_value` is 0 and `max_index` is 0.
- R7: After reset, the bank runs the same sweep. `upd_ready` stays low for N_ENTRIES cycles counted from the release of `rst_n`, and the maximum reads 0 at index 0.
- R8: An accepted update with `upd_index` of N_ENTRIES or more is discarded. It changes no entry and leaves the maximum unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Update request valid |
| upd_index | input | IDX_W | Accumulator to update |
| upd_addend | input | ACC_W | Unsigned value to add |
| upd_ready | output | 1 | Update can be accepted this cycle |
| clr_req | input | 1 | Request to zero all entries and the maximum |
| max_value | output | ACC_W | Largest value written since clear |
| max_index | output | IDX_W | Entry holding max_value |

## Verification
The following are checked on every cycle:
- the one-port RAM never reads and writes in the same cycle;
- a one-port acceptance is always followed by a not-ready cycle;
- two-port mode never drops ready after an acceptance unless a clear is requested;
- a clear request starts the sweep at address 0, and the sweep ends after its last address;
- the maximum never shrinks between clears and is zero after a clear;
- an equal sum never moves the index.

Several properties can only be shown by the bench scenarios:
- that sums are correct, including forwarded back-to-back sums and wrapped sums;
- that a clear really zeroes the stored entries;
- that the sweep length is exact;
- that out-of-range indices are discarded.

// File: rtl/accbank_pkg.sv
package accbank_pkg;
    typedef enum logic {
        ST_SWEEP = 1'b0,
        ST_SERVE = 1'b1
    } bank_state_t;
endpackage

// File: rtl/accbank_mem.sv
module accbank_mem #(
    parameter int DEPTH     = 49,
    parameter int WIDTH     = 32,
    parameter bit DUAL_PORT = 1'b1,
    localparam int AW       = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rd_en,
    input  logic [AW-1:0]    rd_addr,
    output logic [WIDTH-1:0] rd_data,
    input  logic             wr_en,
    input  logic [AW-1:0]    wr_addr,
    input  logic [WIDTH-1:0] wr_data
);
    logic [WIDTH-1:0] store [DEPTH];

    generate
        if (DUAL_PORT) begin : g_two_port
            // independent read and write ports
            always_ff @(posedge clk) begin
                if (rd_en) rd_data <= store[rd_addr];
                if (wr_en) store[wr_addr] <= wr_data;
            end
        end else begin : g_one_port
            // one shared address: a write wins the cycle
            always_ff @(posedge clk) begin
                if (wr_en)      store[wr_addr] <= wr_data;
                else if (rd_en) rd_data <= store[rd_addr];
            end
            assert_port_share_R2: assert property (@(posedge clk) disable iff (!rst_n)
                !(rd_en && wr_en));
        end
    endgenerate
endmodule

// File: rtl/accbank_ctrl.sv
module accbank_ctrl
    import accbank_pkg::*;
#(
    parameter int N_ENTRIES = 49,
    parameter bit DUAL_PORT = 1'b1,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_req,
    input  logic             wb_busy,
    output logic             ready,
    output logic             sweeping,
    output logic             clear_start,
    output logic [IDX_W-1:0] sweep_addr
);
    localparam logic [IDX_W-1:0] LAST_ADDR = IDX_W'(N_ENTRIES - 1);

    bank_state_t st, st_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) st <= ST_SWEEP;
        else        st <= st_nx;
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_SWEEP: if (sweep_addr == LAST_ADDR) st_nx = ST_SERVE;
            ST_SERVE: if (clr_req)                 st_nx = ST_SWEEP;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n || st == ST_SERVE) sweep_addr <= '0;
        else if (sweep_addr != LAST_ADDR) sweep_addr <= sweep_addr + 1'b1;
    end

    always_comb begin
        ready       = 1'b0;
        sweeping    = 1'b0;
        clear_start = 1'b0;
        unique case (st)
            ST_SWEEP: sweeping = 1'b1;
            ST_SERVE: begin
                clear_start = clr_req;
                ready       = !clr_req && (DUAL_PORT || !wb_busy);
            end
        endcase
    end

    assert_sweep_begin_R6: assert property (@(posedge clk) disable iff (!rst_n)
        clear_start |=> (st == ST_SWEEP && sweep_addr == '0));
    assert_sweep_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_SWEEP && sweep_addr == LAST_ADDR) |=> (st == ST_SERVE));
endmodule

// File: rtl/accbank_maxtrk.sv
module accbank_maxtrk #(
    parameter int N_ENTRIES = 49,
    parameter int ACC_W     = 32,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [ACC_W-1:0] wr_sum,
    output logic [ACC_W-1:0] max_value,
    output logic [IDX_W-1:0] max_index
);
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            max_value <= '0;
            max_index <= '0;
        end else if (wr_en && wr_sum > max_value) begin
            max_value <= wr_sum;
            max_index <= wr_idx;
        end
    end

    assert_max_grows_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !flush |=> (max_value >= $past(max_value)));
    assert_flush_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> (max_value == '0 && max_index == '0));
    assert_tie_keeps_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!flush && wr_en && wr_sum == max_value) |=> $stable(max_index));
endmodule

// File: rtl/accum_bank_max.sv
module accum_bank_max #(
    parameter int N_ENTRIES = 49,
    parameter int ACC_W     = 32,
    parameter bit DUAL_PORT = 1'b1,
    localparam int IDX_W    = $clog2(N_ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd_valid,
    input  logic [IDX_W-1:0] upd_index,
    input  logic [ACC_W-1:0] upd_addend,
    output logic             upd_ready,
    input  logic             clr_req,
    output logic [ACC_W-1:0] max_value,
    output logic [IDX_W-1:0] max_index
);
    localparam logic [IDX_W:0] N_LIM = (IDX_W+1)'(N_ENTRIES);

    logic             sweeping, clear_start;
    logic [IDX_W-1:0] sweep_addr;
    logic             take;
    logic             wb_vld;
    logic [IDX_W-1:0] wb_idx;
    logic [ACC_W-1:0] wb_add;
    logic             lw_vld;
    logic [IDX_W-1:0] lw_idx;
    logic [ACC_W-1:0] lw_sum;
    logic [ACC_W-1:0] rd_word, base, sum;
    logic             mem_we;
    logic [IDX_W-1:0] mem_wa;
    logic [ACC_W-1:0] mem_wd;

    assign take = upd_valid && upd_ready && ({1'b0, upd_index} < N_LIM);

    accbank_ctrl #(.N_ENTRIES(N_ENTRIES), .DUAL_PORT(DUAL_PORT)) u_ctrl (
        .clk(clk), .rst_n(rst_n), .clr_req(clr_req), .wb_busy(wb_vld),
        .ready(upd_ready), .sweeping(sweeping), .clear_start(clear_start),
        .sweep_addr(sweep_addr)
    );

    // stage: read issued at acceptance, write-back one cycle later
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_vld <= 1'b0;
            lw_vld <= 1'b0;
        end else begin
            wb_vld <= take;
            lw_vld <= wb_vld;
        end
        wb_idx <= upd_index;
        wb_add <= upd_addend;
        lw_idx <= wb_idx;
        lw_sum <= sum;
    end

    // forward the previous write when it targets the same entry
    assign base = (lw_vld && lw_idx == wb_idx) ? lw_sum : rd_word;
    assign sum  = base + wb_add;

    always_comb begin
        if (sweeping) begin
            mem_we = 1'b1;
            mem_wa = sweep_addr;
            mem_wd = '0;
        end else begin
            mem_we = wb_vld;
            mem_wa = wb_idx;
            mem_wd = sum;
        end
    end

    accbank_mem #(.DEPTH(N_ENTRIES), .WIDTH(ACC_W), .DUAL_PORT(DUAL_PORT)) u_mem (
        .clk(clk), .rst_n(rst_n), .rd_en(take), .rd_addr(upd_index), .rd_data(rd_word),
        .wr_en(mem_we), .wr_addr(mem_wa), .wr_data(mem_wd)
    );

    accbank_maxtrk #(.N_ENTRIES(N_ENTRIES), .ACC_W(ACC_W)) u_max (
        .clk(clk), .rst_n(rst_n), .flush(clear_start),
        .wr_en(wb_vld && !sweeping), .wr_idx(wb_idx), .wr_sum(sum),
        .max_value(max_value), .max_index(max_index)
    );

    generate
        if (DUAL_PORT) begin : g_rate_dp
            assert_full_rate_R3: assert property (@(posedge clk) disable iff (!rst_n)
                take |=> (upd_ready || clr_req));
        end else begin : g_rate_sp
            assert_half_rate_R2: assert property (@(posedge clk) disable iff (!rst_n)
                take |=> !upd_ready);
        end
    endgenerate
endmodule

// File: tb/sim_accum_bank_max.sv
module sim_accum_bank_max;
    localparam int N  = 49;
    localparam int IW = 6;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2 clk = ~clk;

    logic [1:0]          vld = '0, clr = '0, rdy;
    logic [1:0][IW-1:0]  ix = '0, mxi;
    logic [1:0][31:0]    ad = '0, mxv;

    accum_bank_max #(.N_ENTRIES(N), .ACC_W(32), .DUAL_PORT(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .upd_valid(vld[0]), .upd_index(ix[0]),
        .upd_addend(ad[0]), .upd_ready(rdy[0]), .clr_req(clr[0]),
        .max_value(mxv[0]), .max_index(mxi[0]));
    accum_bank_max #(.N_ENTRIES(N), .ACC_W(32), .DUAL_PORT(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .upd_valid(vld[1]), .upd_index(ix[1]),
        .upd_addend(ad[1]), .upd_ready(rdy[1]), .clr_req(clr[1]),
        .max_value(mxv[1]), .max_index(mxi[1]));

    int checks = 0, fails = 0;
    bit done = 0;
    logic [31:0] macc [2][N];
    logic [31:0] mmax [2];
    int          midx [2];

    task automatic report();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    endtask

    task automatic chk(input string rq, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", rq, got, exp);
        end
    endtask

    function automatic void mdl_zero(input int w);
        for (int i = 0; i < N; i++) macc[w][i] = '0;
        mmax[w] = '0;
        midx[w] = 0;
    endfunction

    function automatic void mdl_add(input int w, input int idx, input logic [31:0] a);
        if (idx < N) begin
            macc[w][idx] = macc[w][idx] + a;
            if (macc[w][idx] > mmax[w]) begin
                mmax[w] = macc[w][idx];
                midx[w] = idx;
            end
        end
    endfunction

    task automatic upd(input int w, input int idx, input logic [31:0] a);
        @(negedge clk);
        while (!rdy[w]) begin
            vld[w] = 1'b0;
            @(negedge clk);
        end
        vld[w] = 1'b1;
        ix[w]  = IW'(idx);
        ad[w]  = a;
        mdl_add(w, idx, a);
        @(posedge clk);
    endtask

    task automatic idle(input int w);
        @(negedge clk);
        vld[w] = 1'b0;
    endtask

    task automatic chk_max(input int w, input string rq);
        idle(w);
        repeat (2) @(negedge clk);
        chk(rq, mxv[w], mmax[w]);
        chk(rq, 32'(mxi[w]), 32'(midx[w]));
    endtask

    task automatic do_clear(input int w);
        int n;
        @(negedge clk);
        vld[w] = 1'b0;
        clr[w] = 1'b1;
        #1 chk("R6 ready low in request cycle", 32'(rdy[w]), 0);
        @(negedge clk);
        clr[w] = 1'b0;
        n = 0;
        while (!rdy[w]) begin
            n++;
            @(negedge clk);
        end
        chk("R6 sweep length", n, N);
        mdl_zero(w);
        chk("R6 max value after clear", mxv[w], 0);
        chk("R6 max index after clear", 32'(mxi[w]), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int n;
        void'($urandom(32'h5eed_0042));
        mdl_zero(0);
        mdl_zero(1);
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        // R7: reset sweep
        n = 0;
        while (!rdy[0]) begin
            n++;
            @(negedge clk);
        end
        chk("R7 reset sweep length", n, N);
        chk("R7 max value after reset", mxv[0], 0);
        chk("R7 max index after reset", 32'(mxi[0]), 0);
        chk("R7 max value after reset (one-port)", mxv[1], 0);

        // R1: simple accumulation
        upd(0, 4, 32'd10);
        upd(0, 4, 32'd15);
        chk_max(0, "R1 accumulate entry 4");

        // R3: back-to-back same index, forwarded
        for (int k = 0; k < 5; k++) upd(0, 7, 32'd9 + 32'(k));
        idle(0);
        chk("R3 ready held high after accept", 32'(rdy[0]), 1);
        repeat (2) @(negedge clk);
        chk("R3 back-to-back sum", mxv[0], mmax[0]);
        chk("R3 back-to-back index", 32'(mxi[0]), 32'(midx[0]));

        // R2: one-port rate
        upd(1, 3, 32'd5);
        idle(1);
        chk("R2 ready low after accept", 32'(rdy[1]), 0);
        @(negedge clk);
        chk("R2 ready back after gap", 32'(rdy[1]), 1);
        for (int k = 0; k < 4; k++) upd(1, 3, 32'd2);
        chk_max(1, "R2 one-port accumulate");

        // R5: tie keeps the earlier index
        do_clear(0);
        upd(0, 2, 32'd100);
        upd(0, 9, 32'd60);
        upd(0, 9, 32'd40);
        chk_max(0, "R5 tie value");
        chk("R5 tie index stays 2", 32'(mxi[0]), 2);

        // R8: out-of-range index discarded
        upd(0, 60, 32'hFFFF_0000);
        chk_max(0, "R8 out-of-range ignored");
        chk("R8 max value unchanged", mxv[0], 32'd100);

        // R6: clear zeroes stored entries
        upd(0, 5, 32'd5000);
        chk_max(0, "R6 pre-clear");
        do_clear(0);
        upd(0, 5, 32'd7);
        chk_max(0, "R6 entry zeroed by clear");
        chk("R6 entry 5 restarts from zero", mxv[0], 32'd7);

        // R1/R4: wrap and peak retention
        do_clear(1);
        upd(1, 3, 32'hFFFF_FFF0);
        upd(1, 3, 32'h0000_0020);
        chk_max(1, "R4 peak kept after wrap");
        chk("R4 peak value", mxv[1], 32'hFFFF_FFF0);
        upd(1, 3, 32'hFFFF_FFE8);
        chk_max(1, "R1 wrapped sum exceeds peak");
        chk("R1 wrapped sum value", mxv[1], 32'hFFFF_FFF8);

        // random bursts on both variants
        for (int b = 0; b < 40; b++) begin
            int w, len;
            w = b % 2;
            len = 1 + int'($urandom % 8);
            for (int k = 0; k < len; k++) begin
                int idx;
                logic [31:0] a;
                idx = ($urandom % 4 == 0) ? int'($urandom % 64) : int'($urandom % 6);
                a   = ($urandom % 16 == 0) ? $urandom : ($urandom % 5000);
                upd(w, idx, a);
            end
            chk_max(w, w == 0 ? "R3 random two-port burst" : "R2 random one-port burst");
            if (b % 13 == 12) do_clear(w);
        end
        report();
    end
endmodule